// File: doc/BRIEF.md
# Serial Flash Read Controller

This block is the host side of a serial link to a page-organised flash. A client hands it one read request at a time. Each request names a source, a page, a starting byte and a byte count. The source is a main-array page, first staging buffer or second staging buffer. The block builds the matching command frame and shifts it out MSB first. It keeps select low while the data bytes come back. Each received byte is handed on through a valid/ready output stream.

The serial clock comes from a divider in the system clock domain. Each half period lasts `HALF_DIV` system cycles, which keeps the link under its rate limit at the default settings. Back-pressure rules for the output stream:
- A byte stays on `rd_data` with `rd_valid` high until the cycle in which `rd_ready` is also high.
- While a byte is still waiting, the block may take in at most one more byte.
- After that, the serial clock is held high and the frame is paused until the consumer takes the waiting byte.

Requests use a plain valid/ready pair. `req_ready` is high only when the block is idle. A request that cannot be served is answered with a one-cycle `err` pulse and does not start a frame. A request cannot be served if the byte offset is at or beyond the 264-byte page, the source code is 3, or the count is zero.

Top module: `sflash_rd_ctrl`

## Requirements
- R1: A request with source code 0 (main page) sends, MSB first, the 64-bit frame: opcode 0x52, four 0 bits, the 11-bit page number, the 9-bit byte offset, then 32 zero bits.
- R2: Source code 1 sends opcode 0x54 and source code 2 sends opcode 0x56. Each is followed by fifteen 0 bits, the 9-bit byte offset and eight 0 bits, 40 bits in all.
- R3: Data bits are taken from `spi_miso` on the rising edge of `spi_sclk`, MSB first. Bytes are delivered in the order received. Byte k of a request is the device byte at (offset + k) mod 264 of the named source.
- R4: `spi_sclk` idles low and is low whenever `spi_cs_n` is high. `spi_cs_n` falls before the first frame bit and rises only after the last requested data bit. Exactly frame-length + 8 × count rising edges occur while it is low. `spi_mosi` changes only while `spi_sclk` is low.
- R5: Every high or low phase of `spi_sclk` lasts at least `HALF_DIV` system cycles (13 by default, which gives 4.8 MHz from 125 MHz).
- R6: A request with offset ≥ 264, source code 3 or count 0 raises `err` for exactly the cycle after acceptance. `spi_cs_n` stays high and `busy` stays low.
- R7: While `rd_valid` is high and `rd_ready` is low, `rd_valid` and `rd_data` hold. The block then clocks in at most 8 more data bits before pausing. No byte is lost or repeated.
- R8: Between two frames `spi_cs_n` is high for at least 2 × `HALF_DIV` system cycles. A new frame starts only from a request accepted while `req_ready` was high.
- R9: After reset `spi_cs_n` is 1, `spi_sclk` is 0, `busy`, `err` and `rd_valid` are 0, and `req_ready` is 1. `busy` is high for every cycle in which `spi_cs_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle; request taken this cycle if valid |
| req_kind | input | 2 | Source: 0 main page, 1 buffer one, 2 buffer two, 3 invalid |
| req_page | input | PAGE_W (11) | Page number (main page reads only) |
| req_offset | input | OFF_W (9) | Starting byte within the page or buffer |
| req_count | input | CNT_W (10) | Number of bytes to read |
| busy | output | 1 | Frame or inter-frame gap in progress |
| err | output | 1 | One-cycle pulse: last request rejected |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| rd_valid | output | 1 | Received byte available |
| rd_ready | input | 1 | Consumer accepts the byte |
| rd_data | output | 8 | Received byte |

## Verification
A flash model on the bench decodes every frame from the serial pins and answers from address-dependent memory contents, while the expected bytes come from the request alone. This makes a wrong page, offset or bit order visible as wrong data. Directed frames cover the page-end wrap, the top page number, the last legal offset, single-byte reads and each source code. Separate cases cover the three rejection causes. Random requests run against a randomly stalling consumer, and this is what exposes lost or duplicated bytes. A long directed stall tells a paused clock apart from one that overruns the output register.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam logic [7:0] OP_PAGE = 8'h52;
  localparam logic [7:0] OP_BUF1 = 8'h54;
  localparam logic [7:0] OP_BUF2 = 8'h56;
  localparam int FRAME_BITS = 64;
  localparam int ADDR_BITS  = 24;
  localparam int PAGE_TAIL  = 32;
  localparam int BUF_TAIL   = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_DATA = 2'd2,
    ST_GAP  = 2'd3
  } sfr_state_t;
endpackage

// File: rtl/sfr_frame_build.sv
module sfr_frame_build
  import sfr_pkg::*;
#(
  parameter int PAGE_W     = 11,
  parameter int OFF_W      = 9,
  parameter int CNT_W      = 10,
  parameter int PAGE_BYTES = 264
) (
  input  logic [1:0]        kind,
  input  logic [PAGE_W-1:0] page,
  input  logic [OFF_W-1:0]  offset,
  input  logic [CNT_W-1:0]  count,
  output logic [FRAME_BITS-1:0] frame,
  output logic [5:0]        last_idx,
  output logic              bad
);
  localparam int RSV_W   = ADDR_BITS - PAGE_W - OFF_W;
  localparam int BPRE_W  = ADDR_BITS - OFF_W;
  localparam int BFILL_W = FRAME_BITS - 8 - ADDR_BITS - BUF_TAIL;
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(PAGE_BYTES - 1);

  logic [ADDR_BITS-1:0] page_addr;

  generate
    if (RSV_W > 0) begin : g_rsv
      assign page_addr = {{RSV_W{1'b0}}, page, offset};
    end else begin : g_norsv
      assign page_addr = {page, offset};
    end
  endgenerate

  always_comb begin
    bad = (kind == 2'd3) || (offset > LAST_OFF) || (count == '0);
    if (kind == 2'd0) begin
      frame    = {OP_PAGE, page_addr, {PAGE_TAIL{1'b0}}};
      last_idx = 6'(FRAME_BITS - 1);
    end else begin
      frame    = {(kind == 2'd1) ? OP_BUF1 : OP_BUF2, {BPRE_W{1'b0}}, offset,
                  {BUF_TAIL{1'b0}}, {BFILL_W{1'b0}}};
      last_idx = 6'(8 + ADDR_BITS + BUF_TAIL - 1);
    end
  end
endmodule

// File: rtl/sfr_sclk_gen.sv
module sfr_sclk_gen #(
  parameter int HALF_DIV = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic hold,
  output logic sclk,
  output logic rise,
  output logic fall
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
  localparam int HW = $clog2(HALF_DIV + 1);
  localparam logic [HW-1:0] HSAT = HW'(HALF_DIV);

  logic [CW-1:0] cnt;
  logic          at_end;

  assign at_end = run && (cnt == LAST);
  assign rise   = at_end && !sclk;
  assign fall   = at_end && sclk && !hold;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (at_end) begin
      if (!(sclk && hold)) begin
        cnt  <= '0;
        sclk <= ~sclk;
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // phase-length checker
  logic          seen;
  logic [HW-1:0] hcnt;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen <= 1'b0;
      hcnt <= HSAT;
    end else begin
      seen <= sclk;
      if (sclk != seen)   hcnt <= HW'(1);
      else if (hcnt != HSAT) hcnt <= hcnt + 1'b1;
    end
  end

  p_min_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk != seen) |-> (hcnt >= HSAT));
endmodule

// File: rtl/sfr_rx_stage.sv
module sfr_rx_stage #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic              miso,
  input  logic              push,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr       <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (sample) sr <= {sr[WORD_W-2:0], miso};
      if (push) begin
        rd_data  <= sr;
        rd_valid <= 1'b1;
      end else if (rd_ready) begin
        rd_valid <= 1'b0;
      end
    end
  end

  p_hold_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
endmodule

// File: rtl/sflash_rd_ctrl.sv
module sflash_rd_ctrl
  import sfr_pkg::*;
#(
  parameter int PAGE_W     = 11,
  parameter int OFF_W      = 9,
  parameter int CNT_W      = 10,
  parameter int PAGE_BYTES = 264,
  parameter int HALF_DIV   = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [PAGE_W-1:0] req_page,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [CNT_W-1:0]  req_count,
  output logic              busy,
  output logic              err,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [7:0]        rd_data
);
  localparam int WORD_W  = 8;
  localparam int BC_W    = $clog2(WORD_W + 1);
  localparam int GAP_CYC = 2 * HALF_DIV;
  localparam int GW      = $clog2(GAP_CYC);
  localparam logic [BC_W-1:0] BC_FULL = BC_W'(WORD_W);

  sfr_state_t              state;
  logic [FRAME_BITS-1:0]   frame, hdr_sr;
  logic [5:0]              last_idx, hdr_left;
  logic                    bad;
  logic [BC_W-1:0]         bitc;
  logic [CNT_W-1:0]        bytes_left;
  logic [GW-1:0]           gap_cnt;
  logic                    cs_n_q, mosi_q, err_q;
  logic                    run, hold, rise, fall, push, sample;

  sfr_frame_build #(
    .PAGE_W(PAGE_W), .OFF_W(OFF_W), .CNT_W(CNT_W), .PAGE_BYTES(PAGE_BYTES)
  ) u_build (
    .kind(req_kind), .page(req_page), .offset(req_offset), .count(req_count),
    .frame(frame), .last_idx(last_idx), .bad(bad)
  );

  assign run    = (state == ST_HDR) || (state == ST_DATA);
  assign hold   = (state == ST_DATA) && (bitc == BC_FULL) && rd_valid && !rd_ready;
  assign push   = (state == ST_DATA) && fall && (bitc == BC_FULL);
  assign sample = (state == ST_DATA) && rise;

  sfr_sclk_gen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(run), .hold(hold),
    .sclk(spi_sclk), .rise(rise), .fall(fall)
  );

  sfr_rx_stage #(.WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .sample(sample), .miso(spi_miso), .push(push),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      hdr_sr     <= '0;
      hdr_left   <= '0;
      bitc       <= '0;
      bytes_left <= '0;
      gap_cnt    <= '0;
      cs_n_q     <= 1'b1;
      mosi_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      err_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (req_valid) begin
          if (bad) begin
            err_q <= 1'b1;
          end else begin
            mosi_q     <= frame[FRAME_BITS-1];
            hdr_sr     <= {frame[FRAME_BITS-2:0], 1'b0};
            hdr_left   <= last_idx;
            bytes_left <= req_count;
            bitc       <= '0;
            cs_n_q     <= 1'b0;
            state      <= ST_HDR;
          end
        end
        ST_HDR: if (fall) begin
          if (hdr_left == '0) begin
            mosi_q <= 1'b0;
            state  <= ST_DATA;
          end else begin
            mosi_q   <= hdr_sr[FRAME_BITS-1];
            hdr_sr   <= {hdr_sr[FRAME_BITS-2:0], 1'b0};
            hdr_left <= hdr_left - 1'b1;
          end
        end
        ST_DATA: begin
          if (sample) bitc <= bitc + 1'b1;
          if (push) begin
            bitc       <= '0;
            bytes_left <= bytes_left - 1'b1;
            if (bytes_left == CNT_W'(1)) begin
              cs_n_q  <= 1'b1;
              gap_cnt <= '0;
              state   <= ST_GAP;
            end
          end
        end
        ST_GAP: begin
          if (gap_cnt == GW'(GAP_CYC - 1)) state <= ST_IDLE;
          else gap_cnt <= gap_cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign err       = err_q;
  assign spi_cs_n  = cs_n_q;
  assign spi_mosi  = mosi_q;

  p_busy_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> busy);
  p_reject_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (spi_cs_n && !busy));
  p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);
  p_mosi_low_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && !$fell(spi_cs_n) && $changed(spi_mosi)) |-> !spi_sclk);
  p_gap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |=> spi_cs_n);
  p_start_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> $past(req_valid && req_ready));
endmodule

// File: tb/sflash_rd_ctrl_tb.sv
module sflash_rd_ctrl_tb_top;
  localparam int HALF = 13;
  localparam int PB   = 264;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, busy, err;
  logic [1:0] req_kind;
  logic [10:0] req_page;
  logic [8:0] req_offset;
  logic [9:0] req_count;
  logic cs_n, sclk, mosi, miso;
  logic rd_valid, rd_ready;
  logic [7:0] rd_data;

  always #4 clk = ~clk;

  sflash_rd_ctrl #(.HALF_DIV(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_page(req_page), .req_offset(req_offset),
    .req_count(req_count), .busy(busy), .err(err), .spi_cs_n(cs_n),
    .spi_sclk(sclk), .spi_mosi(mosi), .spi_miso(miso), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data)
  );

  int nchk = 0, nerr = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input int kind, input int page, input int addr);
    case (kind)
      0:       return 8'(page * 13 + addr * 7 + 17);
      1:       return 8'((addr * 5 + 3) ^ 'hC3);
      default: return 8'(addr * 3 + 33 + (addr >> 8));
    endcase
  endfunction

  function automatic logic [63:0] exp_hdr(input int kind, input int page, input int off);
    if (kind == 0) return {8'h52, 4'h0, 11'(page), 9'(off), 32'h0};
    return {24'h0, (kind == 1) ? 8'h54 : 8'h56, 15'h0, 9'(off), 8'h0};
  endfunction

  // queues describing frames in flight and bytes to come
  int fq_kind[$], fq_page[$], fq_off[$], fq_cnt[$];
  logic [7:0] exp_q[$];

  // flash model
  int sbit, slen, idx, addr, skind, spage, soff;
  logic [63:0] cap;
  logic [7:0] sop, mb;
  initial miso = 1'b0;

  always @(negedge cs_n) begin
    sbit = 0; slen = 64; cap = '0;
  end
  always @(posedge sclk) if (!cs_n) begin
    if (sbit < 8 || sbit < slen) cap = {cap[62:0], mosi};
    if (sbit == 7) begin
      sop  = cap[7:0];
      slen = (sop == 8'h52) ? 64 : 40;
    end
    sbit++;
  end
  always @(negedge sclk) if (!cs_n && sbit >= 8 && sbit >= slen) begin
    idx = sbit - slen;
    if (sop == 8'h52) begin skind = 0; spage = int'(cap[51:41]); soff = int'(cap[40:32]); end
    else begin skind = (sop == 8'h54) ? 1 : 2; spage = 0; soff = int'(cap[16:8]); end
    addr = (soff + idx / 8) % PB;
    mb = mem_byte(skind, spage, addr);
    miso <= mb[7 - idx % 8];
  end
  always @(posedge cs_n) if (rst_n) begin
    if (fq_kind.size() == 0) chk(0, "R8", "frame without request", 1, 0);
    else begin
      int k, p, o, c, ln;
      k = fq_kind.pop_front(); p = fq_page.pop_front();
      o = fq_off.pop_front(); c = fq_cnt.pop_front();
      ln = (k == 0) ? 64 : 40;
      chk(cap == exp_hdr(k, p, o), (k == 0) ? "R1" : "R2", "command frame", cap, exp_hdr(k, p, o));
      chk(sbit == ln + 8 * c, "R4", "sclk rises under select", sbit, ln + 8 * c);
    end
  end

  // consumer with selectable back-pressure
  int rdy_mode = 0;
  always @(negedge clk) begin
    if (!rst_n) rd_ready = 1'b0;
    else begin
      case (rdy_mode)
        0: rd_ready = ($urandom % 4) != 0;
        1: rd_ready = 1'b1;
        default: rd_ready = 1'b0;
      endcase
      if (rd_valid && rd_ready) begin
        if (exp_q.size() == 0) chk(0, "R7", "extra byte", rd_data, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rd_data == e, "R3", "data byte", rd_data, e);
        end
      end
    end
  end

  // pin monitor: phases, gap, busy, rise count
  int run_len = 0, min_ph = 1000, hi_run = 0, nframes = 0, busy_bad = 0, rises = 0;
  logic pv_sclk = 1'b0, pv_cs = 1'b1;
  always @(negedge clk) if (rst_n) begin
    if (!cs_n && !busy) busy_bad++;
    if (sclk != pv_sclk) begin
      if (!pv_cs && run_len < min_ph) min_ph = run_len;
      if (sclk) rises++;
      run_len = 1;
    end else run_len++;
    if (cs_n) hi_run++;
    else begin
      if (pv_cs) begin
        if (nframes > 0) chk(hi_run >= 2 * HALF, "R8", "select high gap", hi_run, 2 * HALF);
        nframes++;
      end
      hi_run = 0;
    end
    pv_sclk = sclk; pv_cs = cs_n;
  end

  task automatic send(input int kind, input int page, input int off, input int cnt);
    bit bad;
    int f0;
    bad = (kind == 3) || (off >= PB) || (cnt == 0);
    if (!bad) begin
      fq_kind.push_back(kind); fq_page.push_back(page);
      fq_off.push_back(off); fq_cnt.push_back(cnt);
      for (int i = 0; i < cnt; i++) exp_q.push_back(mem_byte(kind, page, (off + i) % PB));
    end
    req_kind = 2'(kind); req_page = 11'(page); req_offset = 9'(off); req_count = 10'(cnt);
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (bad) begin
      f0 = nframes;
      chk(err == 1'b1, "R6", "err after bad request", err, 1);
      @(negedge clk);
      chk(err == 1'b0, "R6", "err one cycle", err, 0);
      repeat (2 * HALF + 5) @(negedge clk);
      chk(cs_n && !busy && nframes == f0, "R6", "no frame started", {cs_n, busy}, 2'b10);
    end
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy || rd_valid || exp_q.size() != 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [7:0] d0;
    int r0;
    void'($urandom(32'h5eed));
    rst_n = 1'b0; req_valid = 1'b0; req_kind = '0; req_page = '0;
    req_offset = '0; req_count = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b0, "R9", "reset pins", {cs_n, sclk}, 2'b10);
    chk(!busy && !err && !rd_valid && req_ready, "R9", "reset flags",
        {busy, err, rd_valid, req_ready}, 4'b0001);

    // directed frames
    rdy_mode = 1;
    send(0, 5, 10, 4);
    send(0, 2047, 260, 8);   // wraps inside the page
    send(1, 0, 263, 3);      // last legal offset, wraps
    send(2, 100, 0, 5);
    send(0, 0, 0, 1);
    wait_idle();

    // rejected requests
    send(0, 1, 264, 2);
    send(3, 0, 0, 1);
    send(1, 0, 5, 0);

    // long stall: R7
    rdy_mode = 2;
    send(0, 7, 100, 3);
    while (!rd_valid) @(negedge clk);
    d0 = rd_data; r0 = rises;
    repeat (3000) @(negedge clk);
    chk(rises - r0 <= 8, "R7", "bits taken during stall", rises - r0, 8);
    chk(rd_valid && rd_data == d0, "R7", "byte held during stall", rd_data, d0);
    rdy_mode = 0;
    wait_idle();

    // random requests with random back-pressure
    for (int n = 0; n < 16; n++)
      send($urandom % 3, $urandom % 2048, $urandom % PB, 1 + $urandom % 8);
    wait_idle();

    chk(min_ph >= HALF, "R5", "shortest sclk phase", min_ph, HALF);
    chk(busy_bad == 0, "R9", "busy low under select", busy_bad, 0);
    chk(exp_q.size() == 0 && fq_kind.size() == 0, "R7", "all bytes delivered",
        exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule